// File: doc/BRIEF.md
# Subword Rearrangement Unit

This block reorders and narrows the subwords of 64-bit operands for packed media code. It converts wide lanes to half-width lanes with clamping, interleaves the lower or upper lane halves of two operands, and reorders the four 16-bit subwords of one operand under an 8-bit selector. Any selector value is legal, so a subword may appear more than once. It also merges two operands by taking alternating even or odd lanes. A 4x4 matrix of 16-bit elements held in four registers can be transposed with eight such merges.

Each request is presented for one cycle with `in_valid` high. Its result appears in `out_data` one cycle later, qualified by `out_valid`. Lane 0 is the least significant lane of every operand and result.

Top module: `subword_shuffle_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` become 0.
- R2: A request with `in_valid` high produces `out_valid` high and its result on the next cycle. A cycle with `in_valid` low gives `out_valid` low on the next cycle and leaves `out_data` unchanged.
- R3: Op code 0 (narrow) with `in_uns`=0 clamps each signed source lane to the signed range of half its width. Size code 1 narrows 16-bit lanes to bytes and size code 2 narrows 32-bit lanes to 16 bits. Result lanes 0..n-1 come from lanes 0..n-1 of `in_a`, and lanes n..2n-1 come from lanes 0..n-1 of `in_b`.
- R4: Op code 0 with `in_uns`=1 treats each source lane as signed and clamps it to the range 0 .. 2^h-1, where h is the narrow width. Lane placement is the same as in R3.
- R5: Op code 1 (interleave low), with lane width 8, 16 or 32 bits set by size code 0, 1 or 2 and n lanes per operand, sets result lane 2k to `in_a` lane k and result lane 2k+1 to `in_b` lane k, for k < n/2.
- R6: Op code 2 (interleave high) does the same as R5 with source lanes n/2+k.
- R7: Op code 3 (shuffle) sets result subword i to `in_a` subword `in_sel[2i+1:2i]`, with 16-bit subwords. `in_b`, `in_size` and `in_uns` have no effect on it.
- R8: Op code 4 (even merge) sets result lane 2k to `in_a` lane 2k and result lane 2k+1 to `in_b` lane 2k. Op code 5 (odd merge) uses lanes 2k+1 of both operands instead. Lane width follows size codes 0, 1 and 2.
- R9: The result is all zeros for op codes 6 and 7, for size code 3 with any op code except 3, and for op code 0 with size code 0.
- R10: Four 16-lane merges of rows (r0,r1) and (r2,r3), followed by four 32-lane merges of their results, give the four columns of the 4x4 matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 3 | Operation code (0..5, 6 and 7 reserved) |
| in_size | input | 2 | Lane size code: 0=8, 1=16, 2=32 bits, 3 reserved |
| in_uns | input | 1 | Unsigned clamping for narrow |
| in_sel | input | 8 | Shuffle selector, four 2-bit fields |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe |
| out_data | output | 64 | Registered result |

## Verification
The bench builds the unit with its default 64-bit data width. That gives four 16-bit subwords and an 8-bit selector, so the shuffle selector can be covered in full. The three lane widths then yield 8, 4 or 2 lanes per operand. At 2 lanes the interleave and merge ops reduce to a single pair, the edge case for their lane indexing, and the 4x4 transpose can be checked end to end.

// File: rtl/subw_pkg.sv
package subw_pkg;

    typedef enum logic [2:0] {
        OP_NARROW   = 3'd0,
        OP_ILV_LO   = 3'd1,
        OP_ILV_HI   = 3'd2,
        OP_SHUF     = 3'd3,
        OP_ALT_EVEN = 3'd4,
        OP_ALT_ODD  = 3'd5,
        OP_RSV6     = 3'd6,
        OP_RSV7     = 3'd7
    } subw_op_e;

    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_RSV = 2'd3
    } lane_sz_e;

    typedef struct packed {
        subw_op_e op;
        lane_sz_e sz;
        logic     uns;
    } subw_ctrl_t;

    // Number of lanes of width lw in a word of width dw
    function automatic int lane_count(input int dw, input int lw);
        return dw / lw;
    endfunction

endpackage

// File: rtl/subw_narrow.sv
module subw_narrow
    import subw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  lane_sz_e          sz,
    input  logic              uns,
    output logic [DATA_W-1:0] y
);
    localparam int NVAR = 2;

    logic [NVAR-1:0][DATA_W-1:0] res;

    for (genvar g = 0; g < NVAR; g++) begin : g_w
        localparam int SW = 16 << g;
        localparam int H  = SW / 2;
        localparam int N  = lane_count(DATA_W, SW);
        localparam logic signed [SW-1:0] SMAX = SW'((64'd1 << (H - 1)) - 64'd1);
        localparam logic signed [SW-1:0] SMIN = -SMAX - SW'(1);
        localparam logic signed [SW-1:0] UMAX = SW'((64'd1 << H) - 64'd1);

        for (genvar j = 0; j < 2 * N; j++) begin : g_lane
            logic signed [SW-1:0] s;
            logic [H-1:0]         q;
            if (j < N) begin : g_src_a
                assign s = a[j*SW +: SW];
            end else begin : g_src_b
                assign s = b[(j-N)*SW +: SW];
            end
            always_comb begin
                if (uns) begin
                    if (s < 0)          q = '0;
                    else if (s > UMAX)  q = UMAX[H-1:0];
                    else                q = s[H-1:0];
                end else begin
                    if (s > SMAX)       q = SMAX[H-1:0];
                    else if (s < SMIN)  q = SMIN[H-1:0];
                    else                q = s[H-1:0];
                end
            end
            assign res[g][j*H +: H] = q;
        end
    end

    always_comb begin
        case (sz)
            LANE_B16: y = res[0];
            LANE_B32: y = res[1];
            default:  y = '0;
        endcase
    end

endmodule

// File: rtl/subw_interleave.sv
module subw_interleave
    import subw_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  subw_op_e          op,
    input  lane_sz_e          sz,
    output logic [DATA_W-1:0] y
);
    localparam int NSZ = 3;

    // Per lane size: interleave low, interleave high, even merge, odd merge
    logic [NSZ-1:0][DATA_W-1:0] r_lo, r_hi, r_ev, r_od;

    for (genvar g = 0; g < NSZ; g++) begin : g_sz
        localparam int LW   = 8 << g;
        localparam int N    = lane_count(DATA_W, LW);
        localparam int HALF = N / 2;

        for (genvar k = 0; k < HALF; k++) begin : g_pair
            assign r_lo[g][(2*k)*LW   +: LW] = a[k*LW +: LW];
            assign r_lo[g][(2*k+1)*LW +: LW] = b[k*LW +: LW];
            assign r_hi[g][(2*k)*LW   +: LW] = a[(HALF+k)*LW +: LW];
            assign r_hi[g][(2*k+1)*LW +: LW] = b[(HALF+k)*LW +: LW];
            assign r_ev[g][(2*k)*LW   +: LW] = a[(2*k)*LW +: LW];
            assign r_ev[g][(2*k+1)*LW +: LW] = b[(2*k)*LW +: LW];
            assign r_od[g][(2*k)*LW   +: LW] = a[(2*k+1)*LW +: LW];
            assign r_od[g][(2*k+1)*LW +: LW] = b[(2*k+1)*LW +: LW];
        end
    end

    logic [DATA_W-1:0] pick_lo, pick_hi, pick_ev, pick_od;
    logic              sz_ok;

    always_comb begin
        sz_ok   = (sz != LANE_RSV);
        pick_lo = '0;
        pick_hi = '0;
        pick_ev = '0;
        pick_od = '0;
        for (int g = 0; g < NSZ; g++) begin
            if (sz == lane_sz_e'(g)) begin
                pick_lo = r_lo[g];
                pick_hi = r_hi[g];
                pick_ev = r_ev[g];
                pick_od = r_od[g];
            end
        end
    end

    always_comb begin
        y = '0;
        if (sz_ok) begin
            case (op)
                OP_ILV_LO:   y = pick_lo;
                OP_ILV_HI:   y = pick_hi;
                OP_ALT_EVEN: y = pick_ev;
                OP_ALT_ODD:  y = pick_od;
                default:     y = '0;
            endcase
        end
    end

endmodule

// File: rtl/subw_shuffle.sv
module subw_shuffle #(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16,
    parameter int NSUB   = DATA_W / SUB_W,
    parameter int FLD_W  = $clog2(NSUB)
) (
    input  logic [DATA_W-1:0]     a,
    input  logic [NSUB*FLD_W-1:0] sel,
    output logic [DATA_W-1:0]     y
);
    logic [SUB_W-1:0] w [NSUB];

    for (genvar i = 0; i < NSUB; i++) begin : g_split
        assign w[i] = a[i*SUB_W +: SUB_W];
    end

    for (genvar i = 0; i < NSUB; i++) begin : g_dst
        logic [FLD_W-1:0] idx;
        assign idx = sel[i*FLD_W +: FLD_W];
        assign y[i*SUB_W +: SUB_W] = w[idx];
    end

endmodule

// File: rtl/subword_shuffle_unit.sv
module subword_shuffle_unit
    import subw_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int SUB_W  = 16,
    localparam int NSUB  = DATA_W / SUB_W,
    localparam int FLD_W = $clog2(NSUB),
    localparam int SEL_W = NSUB * FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        in_op,
    input  logic [1:0]        in_size,
    input  logic              in_uns,
    input  logic [SEL_W-1:0]  in_sel,
    input  logic [DATA_W-1:0] in_a,
    input  logic [DATA_W-1:0] in_b,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    subw_ctrl_t        ctrl;
    logic [DATA_W-1:0] nar_y, ilv_y, shf_y, nxt;

    assign ctrl.op  = subw_op_e'(in_op);
    assign ctrl.sz  = lane_sz_e'(in_size);
    assign ctrl.uns = in_uns;

    subw_narrow #(.DATA_W(DATA_W)) u_narrow (
        .a(in_a), .b(in_b), .sz(ctrl.sz), .uns(ctrl.uns), .y(nar_y)
    );

    subw_interleave #(.DATA_W(DATA_W)) u_ilv (
        .a(in_a), .b(in_b), .op(ctrl.op), .sz(ctrl.sz), .y(ilv_y)
    );

    subw_shuffle #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_shuf (
        .a(in_a), .sel(in_sel), .y(shf_y)
    );

    always_comb begin
        case (ctrl.op)
            OP_NARROW:                          nxt = nar_y;
            OP_ILV_LO, OP_ILV_HI,
            OP_ALT_EVEN, OP_ALT_ODD:            nxt = ilv_y;
            OP_SHUF:                            nxt = shf_y;
            default:                            nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_data <= nxt;
        end
    end

    // R2: request strobe reaches the output one cycle later
    a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R2: an idle cycle leaves the result untouched
    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_data)));

    // R3: a signed 16-bit lane above the byte range clamps to 0x7F
    a_r3_signed_clamp_hi: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd0 && in_size == 2'd1 && !in_uns &&
         $signed(in_a[15:0]) > 16'sd127) |=> (out_data[7:0] == 8'h7f));

    // R5: byte interleave low puts a lane 0 then b lane 0 at the bottom
    a_r5_ilv_lo_bottom: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd1 && in_size == 2'd0) |=>
        (out_data[15:0] == {$past(in_b[7:0]), $past(in_a[7:0])}));

    // R7: selector field 0 equal to 0 copies subword 0 of in_a
    a_r7_shuf_field0: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op == 3'd3 && in_sel[FLD_W-1:0] == '0) |=>
        (out_data[SUB_W-1:0] == $past(in_a[SUB_W-1:0])));

    // R9: reserved op codes give a zero result
    a_r9_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_op[2:1] == 2'b11) |=> (out_data == '0));

endmodule

// File: tb/subword_shuffle_unit_tb_top.sv
`timescale 1ns/1ps
module subword_shuffle_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [2:0]  in_op;
    logic [1:0]  in_size;
    logic        in_uns;
    logic [7:0]  in_sel;
    logic [63:0] in_a, in_b;
    logic        out_valid;
    logic [63:0] out_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [63:0] exp_q[$];
    string       tag_q[$];
    logic [63:0] last_data = '0;
    bit          mon_on = 0;

    always #10 clk = ~clk;

    subword_shuffle_unit dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_size(in_size), .in_uns(in_uns), .in_sel(in_sel),
        .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_data(out_data)
    );

    function automatic logic [63:0] lane_get(logic [63:0] v, int idx, int w);
        return (v >> (idx * w)) & ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] model(int op, int sz, bit uns,
                                          logic [7:0] sel,
                                          logic [63:0] a, logic [63:0] b);
        logic [63:0] r = '0;
        logic [63:0] x;
        longint v, lo, hi;
        int w, n, h, base, off;
        if (op == 3) begin
            for (int i = 0; i < 4; i++)
                r |= lane_get(a, int'(sel[2*i +: 2]), 16) << (16 * i);
            return r;
        end
        if (op > 5 || sz == 3) return '0;
        w = 8 << sz;
        n = 64 / w;
        case (op)
            0: begin
                if (sz == 0) return '0;
                h  = w / 2;
                lo = uns ? 0 : -(longint'(1) << (h - 1));
                hi = uns ? (longint'(1) << h) - 1 : (longint'(1) << (h - 1)) - 1;
                for (int j = 0; j < 2 * n; j++) begin
                    x = (j < n) ? lane_get(a, j, w) : lane_get(b, j - n, w);
                    v = $signed(x << (64 - w));
                    v = v >>> (64 - w);
                    if (v < lo) v = lo;
                    if (v > hi) v = hi;
                    r |= (64'(v) & ((64'd1 << h) - 64'd1)) << (j * h);
                end
            end
            1, 2: begin
                base = (op == 2) ? n / 2 : 0;
                for (int k = 0; k < n / 2; k++) begin
                    r |= lane_get(a, base + k, w) << (2 * k * w);
                    r |= lane_get(b, base + k, w) << ((2 * k + 1) * w);
                end
            end
            default: begin
                off = (op == 5) ? 1 : 0;
                for (int k = 0; k < n / 2; k++) begin
                    r |= lane_get(a, 2 * k + off, w) << (2 * k * w);
                    r |= lane_get(b, 2 * k + off, w) << ((2 * k + 1) * w);
                end
            end
        endcase
        return r;
    endfunction

    function automatic string req_tag(int op, int sz, bit uns);
        if (op > 5) return "R9";
        if (op == 3) return "R7";
        if (sz == 3 || (op == 0 && sz == 0)) return "R9";
        case (op)
            0: return uns ? "R4" : "R3";
            1: return "R5";
            2: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic drive(int op, int sz, bit uns, logic [7:0] sel,
                         logic [63:0] a, logic [63:0] b,
                         logic [63:0] expv, string tag);
        in_valid = 1'b1;
        in_op    = 3'(op);
        in_size  = 2'(sz);
        in_uns   = uns;
        in_sel   = sel;
        in_a     = a;
        in_b     = b;
        exp_q.push_back(expv);
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send(int op, int sz, bit uns, logic [7:0] sel,
                        logic [63:0] a, logic [63:0] b);
        drive(op, sz, uns, sel, a, b, model(op, sz, uns, sel, a, b),
              req_tag(op, sz, uns));
    endtask

    // Monitor: compare each produced result with the queued expectation
    always @(negedge clk) begin
        if (mon_on && !finished) begin
            if (out_valid) begin
                n_cmp++;
                if (exp_q.size() == 0) begin
                    n_bad++;
                    $display("FAIL R2: unexpected result %h, expected none", out_data);
                end else begin
                    logic [63:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (out_data !== e) begin
                        n_bad++;
                        $display("FAIL %s: got %h expected %h", t, out_data, e);
                    end
                end
                last_data = out_data;
            end else begin
                n_cmp++;
                if (out_data !== last_data) begin
                    n_bad++;
                    $display("FAIL R2: idle changed data got %h expected %h",
                             out_data, last_data);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] m0, m1, m2, m3, t0, t1, t2, t3, c0, c1, c2, c3;
        in_valid = 0; in_op = 0; in_size = 0; in_uns = 0;
        in_sel = 0; in_a = 0; in_b = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        // R1: reset state
        n_cmp++;
        if (out_valid !== 1'b0 || out_data !== 64'd0) begin
            n_bad++;
            $display("FAIL R1: got valid=%b data=%h expected 0/0", out_valid, out_data);
        end
        rst = 0;
        @(negedge clk);
        mon_on = 1;

        // R3 boundaries: 0x7FFF->7F, 0x0080->7F, 0xFF7F->80, 0x007F->7F
        send(0, 1, 0, 8'h00, 64'h007F_FF7F_0080_7FFF, 64'h8000_0001_FF80_FFFF);
        send(0, 2, 0, 8'h00, 64'h0000_8000_FFFF_7FFF, 64'h8000_0000_7FFF_FFFF);
        // R4 boundaries: negative -> 0, above 255 -> FF
        send(0, 1, 1, 8'h00, 64'h00FF_0100_FFFF_0080, 64'h7FFF_8000_0001_0000);
        send(0, 2, 1, 8'h00, 64'h0001_0000_FFFF_FFFF, 64'h0000_FFFF_8000_0000);
        // R5, R6 at each lane size
        for (int s = 0; s < 3; s++) begin
            send(1, s, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
            send(2, s, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
            send(4, s, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
            send(5, s, 0, 0, 64'h0706_0504_0302_0100, 64'h1716_1514_1312_1110);
        end
        // R7: identity, reverse, full repetition, with b/size/uns changing
        send(3, 3, 1, 8'b11_10_01_00, 64'h4444_3333_2222_1111, 64'hFFFF_FFFF_FFFF_FFFF);
        send(3, 0, 0, 8'b00_01_10_11, 64'h4444_3333_2222_1111, 64'h0);
        send(3, 2, 1, 8'b10_10_10_10, 64'h4444_3333_2222_1111, 64'h1234_5678_9ABC_DEF0);
        // R9: reserved codes
        send(6, 1, 0, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1);
        send(7, 0, 1, 8'hFF, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1);
        send(1, 3, 0, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1);
        send(0, 0, 0, 8'h00, 64'hDEAD_BEEF_DEAD_BEEF, 64'h1);
        // R2: idle cycles keep the last result
        repeat (3) @(negedge clk);

        // R10: 4x4 transpose of 16-bit elements, element (r,c) = 0x0rc0+1
        m0 = 64'h0031_0021_0011_0001;
        m1 = 64'h0131_0121_0111_0101;
        m2 = 64'h0231_0221_0211_0201;
        m3 = 64'h0331_0321_0311_0301;
        c0 = 64'h0301_0201_0101_0001;
        c1 = 64'h0311_0211_0111_0011;
        c2 = 64'h0321_0221_0121_0021;
        c3 = 64'h0331_0231_0131_0031;
        t0 = model(4, 1, 0, 0, m0, m1);
        t1 = model(5, 1, 0, 0, m0, m1);
        t2 = model(4, 1, 0, 0, m2, m3);
        t3 = model(5, 1, 0, 0, m2, m3);
        send(4, 1, 0, 0, m0, m1);
        send(5, 1, 0, 0, m0, m1);
        send(4, 1, 0, 0, m2, m3);
        send(5, 1, 0, 0, m2, m3);
        drive(4, 2, 0, 0, t0, t2, c0, "R10");
        drive(4, 2, 0, 0, t1, t3, c1, "R10");
        drive(5, 2, 0, 0, t0, t2, c2, "R10");
        drive(5, 2, 0, 0, t1, t3, c3, "R10");

        // Mixed random traffic with idle gaps (R2..R9)
        for (int i = 0; i < 400; i++) begin
            send(int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
                 1'($urandom_range(0, 1)), 8'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom});
            if ($urandom_range(0, 3) == 0) @(negedge clk);
        end

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R2: %0d results missing, expected 0", exp_q.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule